// File: doc/BRIEF.md
# Vector Signed-Word Saturating Add Unit

This block is one execution slice of a 128-bit SIMD datapath. Each cycle it may accept a 32-bit instruction word together with two 128-bit source vectors. It recognises only the signed-word saturating add encoding. For that instruction it splits both vectors into four 32-bit two's-complement lanes and adds each pair of lanes. Any lane sum that falls outside the signed 32-bit range is clipped to the nearest limit. The clipped result is registered and returned with the destination register index. The register file, fetch, the other vector operations and stores are handled elsewhere.

Next to the datapath sits a vector status register that holds one sticky saturation flag. Any clipping lane of any accepted add sets the flag. Only the separate status-write port can clear it, and that port can also set it. When software writes the flag in the same cycle as a clipping add, the write wins in that cycle, and the add's saturation is merged in one cycle later. Words with a different opcode produce an unsupported indication. They leave the result and the flag untouched.

Top module: `vsat_wadd_unit`

## Requirements
- R1: An instruction is accepted only when instr[31:26] equals 4 and instr[10:0] equals 896, so 0x10000380 is the match with all register fields zero. The fields instr[25:21] (destination), instr[20:16] and instr[15:11] do not affect acceptance.
- R2: Lane 0 is bits [127:96] of each vector and lane 3 is bits [31:0]. When a lane sum fits in signed 32 bits, that lane of res_data equals the sum.
- R3: A lane whose true sum exceeds 2^31−1 yields 0x7FFFFFFF. For example, 0x7FFFFFFF + 1 gives 0x7FFFFFFF.
- R4: A lane whose true sum is below −2^31 yields 0x80000000. For example, 0x80000000 + 0xFFFFFFFF gives 0x80000000.
- R5: A clipping lane has no effect on any other lane, and no carry leaves a lane.
- R6: An accepted instruction in cycle n gives res_valid=1 in cycle n+1, with its result and res_dest = instr[25:21]. Otherwise res_valid is 0.
- R7: stat_sat becomes 1 after an accepted add in which any lane clipped. An add never clears stat_sat.
- R8: When in_valid is 1 with a non-matching word, res_illegal is 1 in the next cycle and res_valid is 0. res_data and stat_sat keep their values.
- R9: When stat_wr_en is 1, stat_sat takes stat_wr_sat in the next cycle, even if an add clips in that same cycle. Saturation from such an add is ORed into stat_sat one cycle later.
- R10: A synchronous active-low reset clears res_valid, res_illegal, res_data, res_dest and stat_sat to 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| stat_wr_en | input | 1 | Write the saturation flag |
| stat_wr_sat | input | 1 | Value for the saturation flag |
| res_valid | output | 1 | Result valid |
| res_data | output | 128 | Clamped lane sums |
| res_dest | output | 5 | Destination register index |
| res_illegal | output | 1 | Unsupported instruction seen last cycle |
| stat_sat | output | 1 | Sticky saturation flag |

## Verification
The bench aims at the two clamp edges: MAX+1 and MIN−1, and sums of two extremes. A design that wraps there would return a value with the opposite sign, and one with the limits swapped would clip to the wrong limit. Directed vectors pair a clipping lane with small neighbours, which catches carries leaking across lanes and a lane order that is reversed. Further cases cover a status write coinciding with a clipping add, and opcode words that differ by one bit. These catch a lost or early saturation merge, a flag that an add clears, and a decoder that looks at the register fields.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

   localparam int REG_IDX_W = 5;

   typedef enum logic [0:0] {
      OVF_SIGN = 1'b0,
      OVF_WIDE = 1'b1
   } ovf_mode_e;

   typedef struct packed {
      logic                 legal;
      logic [REG_IDX_W-1:0] vd;
      logic [REG_IDX_W-1:0] va;
      logic [REG_IDX_W-1:0] vb;
   } dec_t;

endpackage

// File: rtl/vsat_decode.sv
module vsat_decode
   import vsat_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int PRIM_OP = 4,
   parameter int EXT_OP  = 896
) (
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);
   localparam int PRIM_W  = 6;
   localparam int EXT_W   = 11;
   localparam int VD_LSB  = INSTR_W - PRIM_W - REG_IDX_W;
   localparam int VA_LSB  = VD_LSB - REG_IDX_W;
   localparam int VB_LSB  = VA_LSB - REG_IDX_W;

   if (INSTR_W != PRIM_W + 3*REG_IDX_W + EXT_W) begin : g_bad_width
      $error("vsat_decode: instruction width does not fit field layout");
   end

   logic [PRIM_W-1:0] prim;
   logic [EXT_W-1:0]  ext;

   always_comb begin
      prim      = instr[INSTR_W-1 -: PRIM_W];
      ext       = instr[EXT_W-1:0];
      dec.legal = (prim == PRIM_W'(PRIM_OP)) && (ext == EXT_W'(EXT_OP));
      dec.vd    = instr[VD_LSB +: REG_IDX_W];
      dec.va    = instr[VA_LSB +: REG_IDX_W];
      dec.vb    = instr[VB_LSB +: REG_IDX_W];
   end

endmodule

// File: rtl/vsat_lane.sv
module vsat_lane
   import vsat_pkg::*;
#(
   parameter int        W    = 32,
   parameter ovf_mode_e MODE = OVF_SIGN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         clip
);
   localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

   if (W < 2) begin : g_bad_w
      $error("vsat_lane: lane width must be at least 2");
   end

   logic [W-1:0] raw;
   logic         ovf;

   if (MODE == OVF_WIDE) begin : g_wide
      logic [W:0] ext_sum;
      always_comb begin
         ext_sum = {a[W-1], a} + {b[W-1], b};
         raw     = ext_sum[W-1:0];
         ovf     = ext_sum[W] ^ ext_sum[W-1];
      end
   end else begin : g_sign
      always_comb begin
         raw = a + b;
         ovf = (a[W-1] == b[W-1]) && (raw[W-1] != a[W-1]);
      end
   end

   always_comb begin
      clip = ovf;
      if (ovf) sum = a[W-1] ? NEG_LIM : POS_LIM;
      else     sum = raw;
   end

   // Two non-negative operands never give a negative lane (R3)
   always_comb begin
      p_no_wrap_pos_r3: assert (!(!a[W-1] && !b[W-1] && sum[W-1]))
         else $error("positive lane wrapped");
   end
   // Two negative operands never give a non-negative lane (R4)
   always_comb begin
      p_no_wrap_neg_r4: assert (!(a[W-1] && b[W-1] && !sum[W-1]))
         else $error("negative lane wrapped");
   end

endmodule

// File: rtl/vsat_status.sv
module vsat_status (
   input  logic clk,
   input  logic rst_n,
   input  logic add_sat,
   input  logic wr_en,
   input  logic wr_val,
   output logic sat
);
   logic pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sat  <= 1'b0;
         pend <= 1'b0;
      end else if (wr_en) begin
         sat  <= wr_val;
         pend <= pend | add_sat;
      end else begin
         sat  <= sat | add_sat | pend;
         pend <= 1'b0;
      end
   end

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !wr_en) |=> sat)
      else $error("saturation flag cleared without a write");

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (add_sat && !wr_en) |=> sat)
      else $error("clipping add did not set flag");

   p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (sat == $past(wr_val)))
      else $error("status write lost priority");

   p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && add_sat) ##1 !wr_en |=> sat)
      else $error("deferred saturation not merged");

endmodule

// File: rtl/vsat_wadd_unit.sv
module vsat_wadd_unit
   import vsat_pkg::*;
#(
   parameter int        LANES    = 4,
   parameter int        LANE_W   = 32,
   parameter int        INSTR_W  = 32,
   parameter int        PRIM_OP  = 4,
   parameter int        EXT_OP   = 896,
   parameter ovf_mode_e OVF_MODE = OVF_SIGN
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [INSTR_W-1:0]        instr,
   input  logic [LANES*LANE_W-1:0]   src_a,
   input  logic [LANES*LANE_W-1:0]   src_b,
   input  logic                      stat_wr_en,
   input  logic                      stat_wr_sat,
   output logic                      res_valid,
   output logic [LANES*LANE_W-1:0]   res_data,
   output logic [REG_IDX_W-1:0]      res_dest,
   output logic                      res_illegal,
   output logic                      stat_sat
);
   localparam int VEC_W = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("vsat_wadd_unit: need at least one lane");
   end

   dec_t             dec;
   logic [VEC_W-1:0] sum_vec;
   logic [LANES-1:0] clip_vec;
   logic             accept;
   logic             reject;
   logic             add_sat;

   vsat_decode #(
      .INSTR_W (INSTR_W),
      .PRIM_OP (PRIM_OP),
      .EXT_OP  (EXT_OP)
   ) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   // Lane 0 sits in the most-significant word
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int HI = VEC_W - 1 - i*LANE_W;
      vsat_lane #(
         .W    (LANE_W),
         .MODE (OVF_MODE)
      ) u_lane (
         .a    (src_a[HI -: LANE_W]),
         .b    (src_b[HI -: LANE_W]),
         .sum  (sum_vec[HI -: LANE_W]),
         .clip (clip_vec[i])
      );
   end

   always_comb begin
      accept  = in_valid && dec.legal;
      reject  = in_valid && !dec.legal;
      add_sat = accept && (|clip_vec);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         res_data    <= '0;
         res_dest    <= '0;
      end else begin
         res_valid   <= accept;
         res_illegal <= reject;
         if (accept) begin
            res_data <= sum_vec;
            res_dest <= dec.vd;
         end
      end
   end

   vsat_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_sat (add_sat),
      .wr_en   (stat_wr_en),
      .wr_val  (stat_wr_sat),
      .sat     (stat_sat)
   );

   p_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (res_valid && res_dest == $past(instr[INSTR_W-7 -: REG_IDX_W])))
      else $error("accepted add did not produce a result");

   p_ill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (res_illegal && !res_valid && $stable(res_data)))
      else $error("unsupported word disturbed the result");

   p_ill_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !stat_wr_en && !stat_sat) |=> !$rose(stat_sat) || $past(u_stat.pend))
      else $error("unsupported word changed the flag");

   p_reset_r10: assert property (@(posedge clk)
      !rst_n |=> (!res_valid && !res_illegal && !stat_sat && res_data == '0))
      else $error("reset state wrong");

endmodule

// File: tb/vsat_wadd_unit_tb.sv
module vsat_wadd_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] OPW = 32'h1000_0380;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         stat_wr_en = 1'b0;
   logic         stat_wr_sat = 1'b0;
   logic         res_valid;
   logic [127:0] res_data;
   logic [4:0]   res_dest;
   logic         res_illegal;
   logic         stat_sat;

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   logic         m_valid = 0, m_ill = 0, m_sat = 0, m_pend = 0;
   logic [127:0] m_data = '0;
   logic [4:0]   m_dest = '0;
   string        data_tag = "R2";
   string        sat_tag  = "R7";
   bit           force_r5 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vsat_wadd_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .src_a(src_a), .src_b(src_b), .stat_wr_en(stat_wr_en),
      .stat_wr_sat(stat_wr_sat), .res_valid(res_valid), .res_data(res_data),
      .res_dest(res_dest), .res_illegal(res_illegal), .stat_sat(stat_sat)
   );

   function automatic logic [31:0] lane_add(input logic [31:0] a, input logic [31:0] b,
                                            output int kind);
      longint s;
      s = longint'($signed(a)) + longint'($signed(b));
      kind = 0;
      if (s > 64'sd2147483647) begin kind = 1; return 32'h7FFF_FFFF; end
      if (s < -64'sd2147483648) begin kind = 2; return 32'h8000_0000; end
      return s[31:0];
   endfunction

   function automatic bit is_legal(input logic [31:0] w);
      return (w[31:26] == 6'd4) && (w[10:0] == 11'd896);
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b, input bit we, input bit wv);
      logic [127:0] nd;
      bit any_pos, any_neg, any_clip;
      in_valid = v; instr = w; src_a = a; src_b = b;
      stat_wr_en = we; stat_wr_sat = wv;
      any_pos = 0; any_neg = 0;
      for (int i = 0; i < 4; i++) begin
         int k;
         nd[127-32*i -: 32] = lane_add(a[127-32*i -: 32], b[127-32*i -: 32], k);
         if (k == 1) any_pos = 1;
         if (k == 2) any_neg = 1;
      end
      any_clip = v && is_legal(w) && (any_pos || any_neg);
      sat_tag = (we || m_pend) ? "R9" : (v && !is_legal(w)) ? "R8" : "R7";
      if (!(v && is_legal(w)))  data_tag = "R8";
      else if (force_r5)        data_tag = "R5";
      else if (any_pos)         data_tag = "R3";
      else if (any_neg)         data_tag = "R4";
      else                      data_tag = "R2";
      @(posedge clk);
      m_valid = v && is_legal(w);
      m_ill   = v && !is_legal(w);
      if (m_valid) begin m_data = nd; m_dest = w[25:21]; end
      if (we) begin m_sat = wv; m_pend = m_pend | any_clip; end
      else begin m_sat = m_sat | any_clip | m_pend; m_pend = 0; end
      @(negedge clk);
      chk("R6 valid", {127'd0, res_valid}, {127'd0, m_valid});
      chk("R1 illegal", {127'd0, res_illegal}, {127'd0, m_ill});
      chk({data_tag, " data"}, res_data, m_data);
      if (m_valid) chk("R6 dest", {123'd0, res_dest}, {123'd0, m_dest});
      chk({sat_tag, " sat"}, {127'd0, stat_sat}, {127'd0, m_sat});
   endtask

   function automatic logic [31:0] pick();
      case ($urandom % 6)
         0: return 32'h7FFF_FFFF;
         1: return 32'h8000_0000;
         2: return 32'h7FFF_FF00 + ($urandom % 512);
         3: return 32'h8000_0000 + ($urandom % 512);
         4: return $urandom % 256;
         default: return $urandom;
      endcase
   endfunction

   bit done = 0;

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R10: reset state
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10 valid", {127'd0, res_valid}, 128'd0);
      chk("R10 illegal", {127'd0, res_illegal}, 128'd0);
      chk("R10 data", res_data, 128'd0);
      chk("R10 dest", {123'd0, res_dest}, 128'd0);
      chk("R10 sat", {127'd0, stat_sat}, 128'd0);
      rst_n = 1'b1;

      // R1/R2/R6: plain add, bare match word and fields set
      step(1, OPW, {32'd1, 32'd2, 32'hFFFF_FFFF, 32'd100},
                   {32'd10, 32'd20, 32'd1, 32'hFFFF_FF9C}, 0, 0);
      step(1, OPW | (5'd17 << 21) | (5'd3 << 16) | (5'd30 << 11),
           {4{32'd5}}, {4{32'd7}}, 0, 0);
      // R3: MAX + 1
      step(1, OPW, {32'h7FFF_FFFF, 96'd0}, {32'd1, 96'd0}, 0, 0);
      // R9: clear the flag
      step(0, OPW, '0, '0, 1, 0);
      // R4: MIN - 1 in lane 3
      step(1, OPW, {96'd0, 32'h8000_0000}, {96'd0, 32'hFFFF_FFFF}, 0, 0);
      // R8/R1: words one bit off, flag cleared first
      step(0, OPW, '0, '0, 1, 0);
      step(1, OPW ^ 32'h1, {4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 0, 0);
      step(1, OPW ^ 32'h0400_0000, {4{32'h8000_0000}}, {4{32'h8000_0000}}, 0, 0);
      // R5: clipping lane between small neighbours
      force_r5 = 1;
      step(1, OPW, {32'd3, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF},
                   {32'd4, 32'h0000_0010, 32'hFFFF_FFF0, 32'd1}, 0, 0);
      force_r5 = 0;
      // R9: write 0 in the same cycle as a clipping add, then idle
      step(1, OPW, {4{32'h7FFF_FFFF}}, {4{32'd9}}, 1, 0);
      step(0, OPW, '0, '0, 0, 0);
      // R9: write 1 with no add, then write 0
      step(0, OPW, '0, '0, 1, 1);
      step(0, OPW, '0, '0, 1, 0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [127:0] ra, rb;
         logic [31:0]  w;
         for (int i = 0; i < 4; i++) begin
            ra[32*i +: 32] = pick();
            rb[32*i +: 32] = pick();
         end
         w = ($urandom % 8 == 0) ? $urandom : (OPW | ($urandom & 32'h03FF_F800));
         step(($urandom % 4) != 0, w, ra, rb, ($urandom % 10) == 0, $urandom % 2);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule